// File: doc/BRIEF.md
# Single-Cycle Word-Addressed RISC Core

This block is a 32-bit load/store processor that finishes every instruction in the clock cycle that fetches it. An 8-bit program counter addresses a 256-word instruction store. The core reads two operands from a 32-entry register file and runs them through an ALU. It then writes the result to a register or to a 256-word data store. The program counter counts whole words, so the next fetch address is either one past the current one or one past it plus a signed branch offset.

The instruction set covers register add, subtract, AND, OR, NOR and unsigned set-less-than, add-immediate, word load, word store, and branch-if-equal. It also has one custom load whose data address is the difference of two registers. The memories are loaded from outside before reset is released.

The core has no data stream at its edge and never stalls, so there is no valid/ready pair and no back-pressure. Its only inputs are the clock and a synchronous reset. The outputs are plain commit signals. They show, during each cycle, the register write and the data-store write that the next rising edge will perform, together with the current program counter.

Top module: `sc_core`

## Requirements
- R1: While `rst` is 1 at a rising edge, the program counter becomes 0 and every register becomes 0. While `rst` is 1, `rf_we_o` and `dm_we_o` are 0, and the instruction store is deselected, so the fetched word reads as 0.
- R2: Any instruction other than a taken branch-if-equal (opcode 000100) sets the program counter to its current value plus 1, modulo 256.
- R3: Branch-if-equal compares rs (bits 25:21) with rt (bits 20:16) by subtraction. It is taken exactly when the ALU result is zero. When taken, the next program counter is PC + 1 + the low 8 bits of the sign-extended immediate (bits 15:0). The branch writes no register and no memory.
- R4: Opcode 000000 with funct (bits 5:0) 100000 writes rs+rt to rd (bits 15:11), and with funct 100010 writes rs-rt to rd. Opcode 001000 writes rs plus the immediate, with bit 15 copied into bits 31:16, to rt.
- R5: Opcode 000000 with funct 100100, 100101, 100111 and 101010 writes rs AND rt, rs OR rt, NOT(rs OR rt) and (rs < rt unsigned ? 1 : 0) respectively to rd.
- R6: Opcode 100011 loads the data word at the low 8 bits of rs + sign-extended immediate into rt. Opcode 101011 stores rt at that same address and writes no register. A stored word can be read back by the very next load.
- R7: Opcode 000001 loads the data word at the low 8 bits of rs - rt into rd.
- R8: Register 0 always reads as 0, and writes addressed to it have no effect.
- R9: Any other opcode, or opcode 000000 with any other funct, writes no register and no memory and only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 8 | Current program counter (word address) |
| rf_we_o | output | 1 | A register write happens at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | A data-store write happens at the next edge |
| dm_addr_o | output | 8 | Data-store word address in use this cycle |
| dm_wdata_o | output | 32 | Value being stored |

## Verification
The bound checker watches program-counter sequencing on every cycle: reset clears it, non-branches step by one, and branch-if-equal steps by one plus its offset exactly when the operands match. It also checks that reset suppresses every write, that register 0 reads as zero, and that stores and undefined encodings never write a register. The data values themselves cannot be checked this way. These include the sign-extension results, the ALU results per funct code, the wrapped address of the difference load, and the read-back of a word just stored. Only the bench's program can show them, with its behavioural model tracking registers and data memory cycle by cycle. A mid-run reset shows that the program restarts from a cleared register file.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int ILEN  = 32;
  localparam int RADDR = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LWR   = 6'b000001;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND  = 4'd0,
    ALU_OR   = 4'd1,
    ALU_ADD  = 4'd2,
    ALU_SUB  = 4'd6,
    ALU_SLTU = 4'd7,
    ALU_NOR  = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;   // destination from rd field instead of rt
    logic    src_imm;  // second ALU operand is the extended immediate
    logic    wb_mem;   // write back load data instead of ALU result
    logic    reg_we;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLTU;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LWR: begin
        ctrl.dst_rd = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_ADDI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl.reg_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           zero
);
  localparam logic [W-1:0] ONE = 1;

  always_comb begin
    case (op)
      ALU_AND:  res = a & b;
      ALU_OR:   res = a | b;
      ALU_ADD:  res = a + b;
      ALU_SUB:  res = a - b;
      ALU_SLTU: res = (a < b) ? ONE : '0;
      ALU_NOR:  res = ~(a | b);
      default:  res = '0;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_rom.sv
module sc_rom #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign rdata = cs_n ? '0 : mem[addr];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W   = 32,
  parameter int PCW = 8,
  parameter int DAW = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PCW-1:0]   pc_o,
  output logic             rf_we_o,
  output logic [RADDR-1:0] rf_waddr_o,
  output logic [W-1:0]     rf_wdata_o,
  output logic             dm_we_o,
  output logic [DAW-1:0]   dm_addr_o,
  output logic [W-1:0]     dm_wdata_o
);
  localparam int IMMW = 16;
  localparam logic [PCW-1:0] PC_ONE = 1;

  logic [PCW-1:0]   pc_q, pc_nxt;
  logic [ILEN-1:0]  instr;
  ctrl_t            ctrl;
  logic [W-1:0]     rs_val, rt_val, imm_ext, alu_b, alu_res, dm_rdata;
  logic             alu_zero, take;
  logic [RADDR-1:0] rs_f, rt_f, rd_f, waddr;

  // fetch: store is deselected during reset so a zero word is decoded
  sc_rom #(.AW(PCW), .W(ILEN)) u_imem (
    .cs_n  (rst),
    .addr  (pc_q),
    .rdata (instr)
  );

  assign rs_f    = instr[25:21];
  assign rt_f    = instr[20:16];
  assign rd_f    = instr[15:11];
  assign imm_ext = {{(W-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};

  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  sc_regfile #(.W(W), .AW(RADDR)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we_o),
    .waddr   (waddr),
    .wdata   (rf_wdata_o),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(W)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  sc_ram #(.AW(DAW), .W(W)) u_dmem (
    .clk   (clk),
    .we    (dm_we_o),
    .addr  (dm_addr_o),
    .wdata (dm_wdata_o),
    .rdata (dm_rdata)
  );

  assign waddr      = ctrl.dst_rd ? rd_f : rt_f;
  assign rf_we_o    = ctrl.reg_we & ~rst;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = ctrl.wb_mem ? dm_rdata : alu_res;
  assign dm_we_o    = ctrl.mem_we & ~rst;
  assign dm_addr_o  = alu_res[DAW-1:0];
  assign dm_wdata_o = rt_val;

  assign take   = ctrl.branch & alu_zero;
  assign pc_nxt = pc_q + PC_ONE + (take ? imm_ext[PCW-1:0] : '0);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int W   = 32,
  parameter int PCW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PCW-1:0]  pc,
  input logic [ILEN-1:0] instr,
  input logic [W-1:0]    rs_val,
  input logic [W-1:0]    rt_val,
  input logic            rf_we,
  input logic            dm_we
);
  localparam logic [PCW-1:0] ONE = 1;

  logic [5:0] op;
  logic       op_known;
  assign op       = instr[31:26];
  assign op_known = (op == OP_RTYPE) || (op == OP_LWR) || (op == OP_BEQ) ||
                    (op == OP_ADDI) || (op == OP_LW) || (op == OP_SW);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == '0); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ) |=> pc == $past(pc) + ONE); // R2
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val == rt_val) |=> pc == $past(pc) + ONE + $past(instr[PCW-1:0])); // R3
  AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val != rt_val) |=> pc == $past(pc) + ONE); // R3
  AST_BEQ_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ) |-> (!rf_we && !dm_we)); // R3
  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SW) |-> (dm_we && !rf_we)); // R6
  AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == '0) |-> (rs_val == '0)); // R8
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!rf_we && !dm_we)); // R9
endmodule

bind sc_core sc_core_chk #(.W(W), .PCW(PCW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc_o),
  .instr  (instr),
  .rs_val (rs_val),
  .rt_val (rt_val),
  .rf_we  (rf_we_o),
  .dm_we  (dm_we_o)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  import sc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pc_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o, dm_wdata_o;
  logic [7:0]  dm_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sc_core uut (
    .clk(clk), .rst(rst), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  // behavioural reference state
  logic [31:0] prog  [256];
  logic [31:0] m_dm  [256];
  logic [31:0] m_reg [32];
  logic [7:0]  m_pc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    logic [4:0] a = rs[4:0], b = rt[4:0], d = rd[4:0];
    return {OP_RTYPE, a, b, d, 5'b0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    logic [4:0] a = rs[4:0], b = rt[4:0];
    logic [15:0] k = imm[15:0];
    return {op, a, b, k};
  endfunction

  function automatic logic [31:0] enc_lwr(int rs, int rt, int rd);
    logic [4:0] a = rs[4:0], b = rt[4:0], d = rd[4:0];
    return {OP_LWR, a, b, d, 11'b0};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    if (op == OP_RTYPE && (ins[15:11] == 5'd0 || ins[25:21] == 5'd0)) return "R8";
    if (op == OP_ADDI && ins[20:16] == 5'd0) return "R8";
    case (op)
      OP_RTYPE: begin
        if (fn == FN_ADD || fn == FN_SUB) return "R4";
        if (fn == FN_AND || fn == FN_OR || fn == FN_NOR || fn == FN_SLT) return "R5";
        return "R9";
      end
      OP_ADDI: return "R4";
      OP_LW, OP_SW: return "R6";
      OP_LWR: return "R7";
      OP_BEQ: return "R3";
      default: return "R9";
    endcase
  endfunction

  // compare this cycle's commit outputs, then advance the model by one edge
  task automatic step(input bit in_rst, inout string pc_tag);
    logic [31:0] ins, a, b, se, r, t;
    logic [4:0]  rs, rt, rd;
    logic        e_we, e_dwe, ok;
    logic [4:0]  e_wa;
    logic [31:0] e_wd, e_dd;
    logic [7:0]  e_da, npc;
    string       tg;
    ins = in_rst ? 32'h0 : prog[m_pc];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    se = {{16{ins[15]}}, ins[15:0]};
    a  = (rs == 0) ? 32'h0 : m_reg[rs];
    b  = (rt == 0) ? 32'h0 : m_reg[rt];
    e_we = 0; e_dwe = 0; e_wa = 0; e_wd = 0; e_da = 0; e_dd = 0;
    npc = m_pc + 8'd1;
    tg  = in_rst ? "R1" : tag_of(ins);
    if (!in_rst) begin
      case (ins[31:26])
        OP_RTYPE: begin
          ok = 1;
          case (ins[5:0])
            FN_ADD: r = a + b;
            FN_SUB: r = a - b;
            FN_AND: r = a & b;
            FN_OR:  r = a | b;
            FN_NOR: r = ~(a | b);
            FN_SLT: r = (a < b) ? 32'd1 : 32'd0;
            default: begin ok = 0; r = 0; end
          endcase
          if (ok) begin e_we = 1; e_wa = rd; e_wd = r; end
        end
        OP_ADDI: begin e_we = 1; e_wa = rt; e_wd = a + se; end
        OP_LW: begin t = a + se; e_we = 1; e_wa = rt; e_wd = m_dm[t[7:0]]; end
        OP_SW: begin t = a + se; e_dwe = 1; e_da = t[7:0]; e_dd = b; end
        OP_LWR: begin t = a - b; e_we = 1; e_wa = rd; e_wd = m_dm[t[7:0]]; end
        OP_BEQ: if (a == b) npc = m_pc + 8'd1 + se[7:0];
        default: ;
      endcase
    end
    chk(pc_tag, "pc", pc_o, m_pc);
    chk(tg, "rf_we", rf_we_o, e_we);
    chk(tg, "dm_we", dm_we_o, e_dwe);
    if (e_we) begin
      chk(tg, "rf_waddr", rf_waddr_o, e_wa);
      chk(tg, "rf_wdata", rf_wdata_o, e_wd);
    end
    if (e_dwe) begin
      chk(tg, "dm_addr", dm_addr_o, e_da);
      chk(tg, "dm_wdata", dm_wdata_o, e_dd);
    end
    if (in_rst) begin
      m_pc = 0;
      for (int i = 0; i < 32; i++) m_reg[i] = 0;
      pc_tag = "R1";
    end else begin
      if (e_we && e_wa != 0) m_reg[e_wa] = e_wd;
      if (e_dwe) m_dm[e_da] = e_dd;
      pc_tag = (ins[31:26] == OP_BEQ) ? "R3" : "R2";
      m_pc = npc;
    end
  endtask

  initial begin
    string pt;
    for (int i = 0; i < 256; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(OP_ADDI, 0, 1, 5);          // r1 = 5
    prog[1]  = enc_i(OP_ADDI, 0, 2, -3);         // r2 = -3 (sign extension)
    prog[2]  = enc_r(1, 2, 3, FN_ADD);           // r3 = 2
    prog[3]  = enc_r(1, 2, 4, FN_SUB);           // r4 = 8
    prog[4]  = enc_r(1, 2, 5, FN_AND);
    prog[5]  = enc_r(1, 2, 6, FN_OR);
    prog[6]  = enc_r(1, 2, 7, FN_SLT);           // unsigned: 1
    prog[7]  = enc_r(1, 2, 8, FN_NOR);
    prog[8]  = enc_i(OP_ADDI, 0, 0, 7);          // write to r0 ignored
    prog[9]  = enc_r(0, 1, 10, FN_ADD);          // r10 = 5, r0 still 0
    prog[10] = enc_i(OP_LW, 1, 11, 4);           // dm[9]
    prog[11] = enc_i(OP_SW, 3, 4, 2);            // dm[4] = 8
    prog[12] = enc_i(OP_LW, 3, 12, 2);           // read back 8
    prog[13] = enc_lwr(1, 3, 13);                // dm[3]
    prog[14] = enc_r(1, 2, 14, 6'b000000);       // unknown funct: no-op
    prog[15] = enc_i(OP_BEQ, 1, 10, 1);          // taken, skips 16
    prog[16] = enc_i(OP_ADDI, 0, 15, 99);
    prog[17] = enc_i(OP_BEQ, 1, 2, 5);           // not taken
    prog[18] = enc_i(OP_ADDI, 0, 9, 3);
    prog[19] = enc_i(OP_ADDI, 9, 9, -1);
    prog[20] = enc_i(OP_BEQ, 9, 0, 1);           // exit loop when r9 == 0
    prog[21] = enc_i(OP_BEQ, 0, 0, -3);          // backward branch to 19
    prog[22] = {6'b000010, 26'h155};             // undefined opcode
    prog[23] = enc_lwr(3, 1, 16);                // 2-5 wraps to dm[253]
    prog[24] = enc_i(OP_BEQ, 0, 0, -1);          // park
    for (int i = 0; i < 256; i++) m_dm[i] = i * 10 + 1;
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    m_pc = 0;
    #1;
    for (int i = 0; i < 256; i++) begin
      uut.u_imem.mem[i] = prog[i];
      uut.u_dmem.mem[i] = m_dm[i];
    end
    repeat (2) @(posedge clk);
    pt = "R1";
    for (int cyc = 0; cyc < 100; cyc++) begin
      bit r;
      @(negedge clk);
      r = (cyc < 2) || (cyc >= 70 && cyc < 72);
      rst = r;
      #1;
      step(r, pt);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule